// File: doc/BRIEF.md
# Floating-Point Exception Flag Accumulator

This block keeps the floating-point status word of a processor core. After each arithmetic operation the execution unit presents a five-bit vector of IEEE exception flags with a one-cycle strobe. The block merges those flags into the current-exception field, then compares the merged field with the trap-enable field of the same register.

If any merged flag is enabled, the block writes the IEEE-exception code into the trap-type field and raises a one-cycle trap request toward the exception logic. The accrued field is left as it was. If no merged flag is enabled, the block ORs the merged current flags into the accrued field and raises no request.

Software can load the whole status word through a write port. A write takes precedence over a flag strobe that arrives in the same cycle.

Top module: `fpx_flag_accum`

## Requirements
- R1: Flag bit positions are the same in `flag_vec`, the current field (`status_o[4:0]`), the accrued field (`status_o[9:5]`) and the enable field (`status_o[27:23]`): bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. A strobe without a write ORs `flag_vec` into the current field one cycle later. Current bits already set stay set.
- R2: A strobe with a non-zero flag vector and no write causes a trap if, for some bit i of the merged current field, `status_o[23+i]` is 1. No other condition causes a trap.
- R3: When a trap occurs, the next status has the merged current field, `status_o[16:14]` set to 1 (the IEEE-exception code), and every other bit unchanged. This includes the accrued field.
- R4: `trap_req_o` is high for exactly the one cycle after each trapping strobe and low in every other cycle.
- R5: A strobe with a non-zero flag vector that causes no trap ORs the merged current field into the accrued field `status_o[9:5]`. The trap-type field and all other bits stay unchanged.
- R6: A strobe with an all-zero flag vector leaves `status_o` unchanged and raises no trap request.
- R7: When `sw_we` is high, `status_o` equals `sw_wdata` on the next cycle. Any flag strobe in that same cycle is discarded and raises no trap request.
- R8: While `rst_n` is low, `status_o` is all zero and `trap_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_vld | input | 1 | One-cycle strobe: `flag_vec` holds the flags of one operation |
| flag_vec | input | 5 | IEEE exception flags from the arithmetic unit |
| sw_we | input | 1 | Software write enable for the status word |
| sw_wdata | input | 32 | Value written to the status word |
| status_o | output | 32 | Registered status word |
| trap_req_o | output | 1 | One-cycle trap request |

## Verification
A software write and a flag strobe can arrive in the same cycle. The bench provokes this with directed cases in which the written enables would trap the incoming flags, and with random cycles in which both inputs are drawn independently. In each case the status must equal the written word and the trap request must stay low, which shows the strobe was discarded entirely. A second overlap is between a strobe and flags still held in the current field from an earlier strobe: a new flag that is not enabled can trap because of an enabled bit set before. The bench model checks this on every strobe.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int unsigned FPX_STAT_W   = 32;
    localparam int unsigned FPX_NFLAG    = 5;
    localparam int unsigned FPX_CEXC_LSB = 0;
    localparam int unsigned FPX_AEXC_LSB = FPX_CEXC_LSB + FPX_NFLAG;
    localparam int unsigned FPX_TEM_LSB  = 23;
    localparam int unsigned FPX_FTT_LSB  = 14;
    localparam int unsigned FPX_FTT_W    = 3;
    localparam int unsigned FPX_FTT_IEEE = 1;

endpackage

// File: rtl/fpx_trap_detect.sv
module fpx_trap_detect #(
    parameter int unsigned NFLAG = 5
) (
    input  logic [NFLAG-1:0] cexc_cur,
    input  logic [NFLAG-1:0] flag_in,
    input  logic [NFLAG-1:0] tem_in,
    output logic [NFLAG-1:0] cexc_new,
    output logic             trap_hit
);

    logic [NFLAG-1:0] hit;

    // Per-flag merge and enable match.
    generate
        for (genvar g = 0; g < NFLAG; g++) begin : g_flag
            assign cexc_new[g] = cexc_cur[g] | flag_in[g];
            assign hit[g]      = cexc_new[g] & tem_in[g];
        end
    endgenerate

    assign trap_hit = |hit;

endmodule

// File: rtl/fpx_field_merge.sv
module fpx_field_merge #(
    parameter int unsigned    STAT_W   = 32,
    parameter int unsigned    NFLAG    = 5,
    parameter int unsigned    CEXC_LSB = 0,
    parameter int unsigned    AEXC_LSB = 5,
    parameter int unsigned    FTT_LSB  = 14,
    parameter int unsigned    FTT_W    = 3,
    parameter int unsigned    FTT_CODE = 1
) (
    input  logic [STAT_W-1:0] status_cur,
    input  logic [NFLAG-1:0]  cexc_new,
    input  logic              trap_hit,
    output logic [STAT_W-1:0] status_upd
);

    localparam logic [FTT_W-1:0] FTT_VAL = FTT_W'(FTT_CODE);

    always_comb begin
        status_upd                      = status_cur;
        status_upd[CEXC_LSB +: NFLAG]   = cexc_new;
        if (trap_hit) begin
            status_upd[FTT_LSB +: FTT_W] = FTT_VAL;
        end else begin
            status_upd[AEXC_LSB +: NFLAG] = status_cur[AEXC_LSB +: NFLAG] | cexc_new;
        end
    end

endmodule

// File: rtl/fpx_flag_accum.sv
module fpx_flag_accum
    import fpx_pkg::*;
#(
    parameter int unsigned STAT_W   = FPX_STAT_W,
    parameter int unsigned NFLAG    = FPX_NFLAG,
    parameter int unsigned CEXC_LSB = FPX_CEXC_LSB,
    parameter int unsigned AEXC_LSB = FPX_AEXC_LSB,
    parameter int unsigned TEM_LSB  = FPX_TEM_LSB,
    parameter int unsigned FTT_LSB  = FPX_FTT_LSB,
    parameter int unsigned FTT_W    = FPX_FTT_W,
    parameter int unsigned FTT_CODE = FPX_FTT_IEEE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_vld,
    input  logic [NFLAG-1:0]  flag_vec,
    input  logic              sw_we,
    input  logic [STAT_W-1:0] sw_wdata,
    output logic [STAT_W-1:0] status_o,
    output logic              trap_req_o
);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic              trap;
    } acc_state_t;

    acc_state_t state_d, state_q;

    logic [NFLAG-1:0]  cexc_new;
    logic              trap_hit;
    logic [STAT_W-1:0] status_upd;
    logic              flag_live;

    assign flag_live = flag_vld && (flag_vec != '0);

    fpx_trap_detect #(
        .NFLAG (NFLAG)
    ) u_detect (
        .cexc_cur (state_q.status[CEXC_LSB +: NFLAG]),
        .flag_in  (flag_vec),
        .tem_in   (state_q.status[TEM_LSB +: NFLAG]),
        .cexc_new (cexc_new),
        .trap_hit (trap_hit)
    );

    fpx_field_merge #(
        .STAT_W   (STAT_W),
        .NFLAG    (NFLAG),
        .CEXC_LSB (CEXC_LSB),
        .AEXC_LSB (AEXC_LSB),
        .FTT_LSB  (FTT_LSB),
        .FTT_W    (FTT_W),
        .FTT_CODE (FTT_CODE)
    ) u_merge (
        .status_cur (state_q.status),
        .cexc_new   (cexc_new),
        .trap_hit   (trap_hit),
        .status_upd (status_upd)
    );

    always_comb begin
        state_d       = state_q;
        state_d.trap  = 1'b0;
        if (sw_we) begin
            state_d.status = sw_wdata;
        end else if (flag_live) begin
            state_d.status = status_upd;
            state_d.trap   = trap_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o   = state_q.status;
    assign trap_req_o = state_q.trap;

    AST_CEXC_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vld && !sw_we) |=> ((status_o[CEXC_LSB +: NFLAG] & $past(flag_vec)) == $past(flag_vec))); // R1
    AST_TRAP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> $past(flag_vld && !sw_we && (flag_vec != '0))); // R2
    AST_TRAP_SETS_FTT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> (status_o[FTT_LSB +: FTT_W] == FTT_W'(FTT_CODE))); // R3
    AST_TRAP_KEEPS_ACCRUED: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> (status_o[AEXC_LSB +: NFLAG] == $past(status_o[AEXC_LSB +: NFLAG]))); // R3
    AST_ACCRUE_COVERS_CEXC: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_live && !sw_we) |=> (trap_req_o ||
            ((status_o[AEXC_LSB +: NFLAG] & status_o[CEXC_LSB +: NFLAG]) == status_o[CEXC_LSB +: NFLAG]))); // R5
    AST_ZERO_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vld && (flag_vec == '0) && !sw_we) |=> ($stable(status_o) && !trap_req_o)); // R6
    AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> ((status_o == $past(sw_wdata)) && !trap_req_o)); // R7

endmodule

// File: tb/fpx_flag_accum_tb_top.sv
`timescale 1ns/1ps
module fpx_flag_accum_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_vld = 1'b0;
    logic [4:0]  flag_vec = '0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] status_o;
    logic        trap_req_o;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    logic [31:0] exp_status = '0;
    logic        exp_trap = 1'b0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    fpx_flag_accum dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_vld   (flag_vld),
        .flag_vec   (flag_vec),
        .sw_we      (sw_we),
        .sw_wdata   (sw_wdata),
        .status_o   (status_o),
        .trap_req_o (trap_req_o)
    );

    // Reference model built from the requirements: returns {trap, status}.
    function automatic logic [32:0] model(input logic [31:0] s, input logic vld,
                                          input logic [4:0] f, input logic we,
                                          input logic [31:0] wd);
        logic [31:0] n;
        logic [4:0]  c;
        logic        t;
        n = s;
        t = 1'b0;
        if (we) begin
            n = wd;
        end else if (vld && f != 5'd0) begin
            c = s[4:0] | f;
            t = |(c & s[27:23]);
            n[4:0] = c;
            if (t) n[16:14] = 3'd1;
            else   n[9:5]   = s[9:5] | c;
        end
        return {t, n};
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic step(input logic vld, input logic [4:0] f, input logic we, input logic [31:0] wd);
        logic [32:0] r;
        string       tag;
        @(negedge clk);
        flag_vld = vld; flag_vec = f; sw_we = we; sw_wdata = wd;
        r = model(exp_status, vld, f, we, wd);
        if (we)                 tag = "R7";
        else if (vld && f == 0) tag = "R6";
        else if (vld && r[32])  tag = "R3";
        else if (vld)           tag = "R5";
        else                    tag = "R4";
        @(posedge clk);
        #1;
        exp_status = r[31:0];
        exp_trap   = r[32];
        check32(tag, status_o, exp_status);
        if (vld && !we && f != 0) check32("R1", {27'd0, status_o[4:0] & f}, {27'd0, f});
        check32((vld && !we) ? "R2" : "R4", {31'd0, trap_req_o}, {31'd0, exp_trap});
        @(negedge clk);
        flag_vld = 1'b0; sw_we = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        check32("R8", status_o, 32'd0);
        check32("R8", {31'd0, trap_req_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Zero-flag strobe on a populated register (R6).
        step(1'b0, 5'd0, 1'b1, 32'h0080_0021);
        step(1'b1, 5'd0, 1'b0, 32'd0);
        // Inexact, not enabled: accrues (R5).
        step(1'b0, 5'd0, 1'b1, 32'h0000_0000);
        step(1'b1, 5'b00001, 1'b0, 32'd0);
        // Enable invalid (bit 27), then invalid: trap (R3, R4).
        step(1'b0, 5'd0, 1'b1, 32'h0800_0000);
        step(1'b1, 5'b10000, 1'b0, 32'd0);
        // A held current bit traps again with a non-enabled new flag (R2).
        step(1'b1, 5'b00010, 1'b0, 32'd0);
        step(1'b0, 5'd0, 1'b0, 32'd0);
        // Write and strobe together: write wins, no trap (R7).
        step(1'b1, 5'b10000, 1'b1, 32'h0800_0010);
        step(1'b0, 5'd0, 1'b0, 32'd0);

        for (int i = 0; i < 3000; i++) begin
            logic        v, w;
            logic [4:0]  f;
            logic [31:0] d;
            v = ($urandom % 3) != 0;
            f = (($urandom % 8) == 0) ? 5'd0 : 5'($urandom);
            w = ($urandom % 6) == 0;
            d = $urandom;
            if (($urandom % 2) == 0) d[4:0] = 5'd0;
            if (($urandom % 3) == 0) d[27:23] = 5'd0;
            step(v, f, w, d);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule